// File: doc/BRIEF.md
# Register-Offset Sign-Extending Load/Store Unit

This block runs one class of 16-bit compressed memory instruction. It reads a base register and an offset register from an eight-entry, 32-bit register file. It adds them to form a byte address. Then it does one of four things: it writes a halfword to memory, reads a halfword and zero-fills the upper bits, reads a byte and sign-fills, or reads a halfword and sign-fills. Only the loads write back to the register file.

The unit takes one instruction at a time, through a valid strobe, while it is idle. It drives the register file read addresses from fields it has latched. It makes a single request on a little-endian 32-bit memory port with per-byte enables. It ends every accepted instruction with a one-cycle completion pulse. A halfword access at an odd address is refused and flagged. A word that is not of this class is dropped and flagged.

Top module: `regoff_ldst`

## Requirements
- R1: An instruction matches when bits 15:12 are 0101 and bit 9 is 1. Within it, bit 11 is H and bit 10 is S. Bits 8:6 name the offset register, bits 5:3 the base register, and bits 2:0 the data register. The data register is the write-back target for loads and the source for stores.
- R2: The effective address is the 32-bit wrapping sum of the base and offset register values. It appears unchanged on `mem_addr` while `mem_req` is high.
- R3: S=0,H=0 stores a halfword. `mem_we` is 1. `mem_be` is 0011 when address bit 1 is 0 and 1100 when it is 1. `mem_wdata` holds the data register's bits 15:0 in both halves. No register is written.
- R4: S=0,H=1 loads the halfword at bits 16*addr[1]+15:16*addr[1] of the read word into the data register's bits 15:0 and clears bits 31:16. The halfword enables follow R3.
- R5: S=1,H=0 loads byte addr[1:0] (bits 8n+7:8n of the read word) into bits 7:0 and copies bit 7 into bits 31:8. The request carries the single enable bit n.
- R6: S=1,H=1 loads the selected halfword into bits 15:0 and copies bit 15 into bits 31:16.
- R7: Let cycle k be the cycle in which `instr_valid` is accepted. A store then has `mem_req`, `mem_we` and `done` high in cycle k+2. A load has `mem_req` in cycle k+2, with read data expected on `mem_rdata` in cycle k+3. In cycle k+3 it has `rf_we` and `done` high. `done` lasts one cycle.
- R8: A halfword access (store, R4 or R6) whose address has bit 0 set raises `align_err` and `done` together in cycle k+2. No memory request and no register write take place. Byte loads at any address proceed normally.
- R9: A non-matching word offered while idle raises `unhandled` for one cycle in cycle k+1. It causes no memory request, no register write and no `done`.
- R10: `instr_valid` is ignored while `busy` is high. The instruction in flight uses only the fields latched at acceptance.
- R11: During and right after reset, `busy`, `done`, `mem_req`, `mem_we`, `rf_we`, `align_err` and `unhandled` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | Instruction offered |
| instr | input | 16 | Instruction word |
| busy | output | 1 | Instruction in flight; new offers are ignored |
| rf_base_addr | output | 3 | Register file read index, base |
| rf_base_data | input | 32 | Base register value |
| rf_off_addr | output | 3 | Register file read index, offset |
| rf_off_data | input | 32 | Offset register value |
| rf_src_addr | output | 3 | Register file read index, store source |
| rf_src_data | input | 16 | Low halfword of the store source register |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 3 | Register write index |
| rf_wdata | output | 32 | Extended load result |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| done | output | 1 | Completion pulse |
| align_err | output | 1 | Odd-address halfword refused |
| unhandled | output | 1 | Non-matching instruction dropped |

## Verification
Most internal faults in this unit show up at the ports within one to three cycles of acceptance. If a field is latched from the wrong bits, the wrong read index or write index appears in the address cycle or the write-back cycle. If the lane selection or the fill logic is wrong, `rf_wdata` is wrong in the write-back cycle. If the state sequence is wrong, `done` or `mem_req` moves off its expected cycle, or a write appears without `done`. Each completion is matched against a queued expectation, so a stray or missing completion is caught as soon as it happens.

// File: rtl/rol_pkg.sv
package rol_pkg;
  localparam int IW  = 16;
  localparam int RIW = 3;

  // encoded as {S, H}
  typedef enum logic [1:0] {
    OP_STH  = 2'b00,
    OP_LDH  = 2'b01,
    OP_LDSB = 2'b10,
    OP_LDSH = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_MEM,
    ST_WB,
    ST_FAULT
  } st_e;

  typedef struct packed {
    logic           match;
    op_e            op;
    logic [RIW-1:0] ro;
    logic [RIW-1:0] rb;
    logic [RIW-1:0] rd;
  } dec_t;
endpackage

// File: rtl/rol_rst_sync.sv
module rol_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= 2'b00;
    else              sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rol_decode.sv
module rol_decode
  import rol_pkg::*;
(
  input  logic [IW-1:0] instr_i,
  output dec_t          dec_o
);
  assign dec_o.match = (instr_i[15:12] == 4'b0101) && instr_i[9];
  assign dec_o.op    = op_e'({instr_i[10], instr_i[11]});
  assign dec_o.ro    = instr_i[8:6];
  assign dec_o.rb    = instr_i[5:3];
  assign dec_o.rd    = instr_i[2:0];
endmodule

// File: rtl/rol_lane.sv
module rol_lane
  import rol_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]               rdata_i,
  input  logic [$clog2(DW/8)-1:0]     off_i,
  input  op_e                         op_i,
  output logic [DW-1:0]               ext_o
);
  localparam int NLANE = DW / 8;
  localparam int LSB   = $clog2(NLANE);

  logic [7:0]  byte_l [NLANE];
  logic [15:0] half_l [NLANE/2];

  for (genvar g = 0; g < NLANE; g++) begin : g_byte
    assign byte_l[g] = rdata_i[8*g +: 8];
  end

  for (genvar g = 0; g < NLANE/2; g++) begin : g_half
    assign half_l[g] = rdata_i[16*g +: 16];
  end

  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  assign sel_b = byte_l[off_i];
  assign sel_h = half_l[off_i[LSB-1:1]];

  always_comb begin
    unique case (op_i)
      OP_LDSB: ext_o = {{(DW-8){sel_b[7]}}, sel_b};
      OP_LDH:  ext_o = {{(DW-16){1'b0}}, sel_h};
      OP_LDSH: ext_o = {{(DW-16){sel_h[15]}}, sel_h};
      default: ext_o = '0;
    endcase
  end
endmodule

// File: rtl/rol_ctrl.sv
module rol_ctrl
  import rol_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic valid_i,
  input  logic match_i,
  input  logic misalign_i,
  input  logic store_i,
  output st_e  st_o
);
  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (valid_i && match_i) st_d = ST_ADDR;
      ST_ADDR:  st_d = misalign_i ? ST_FAULT : ST_MEM;
      ST_MEM:   st_d = store_i ? ST_IDLE : ST_WB;
      ST_WB:    st_d = ST_IDLE;
      ST_FAULT: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign st_o = st_q;

  AST_FAULT_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FAULT) |-> ($past(st_q) == ST_ADDR)); // R8

  AST_ADDR_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADDR) |-> ($past(st_q) == ST_IDLE)); // R10
endmodule

// File: rtl/regoff_ldst.sv
module regoff_ldst
  import rol_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [IW-1:0]     instr,
  output logic              busy,
  output logic [RIW-1:0]    rf_base_addr,
  input  logic [DW-1:0]     rf_base_data,
  output logic [RIW-1:0]    rf_off_addr,
  input  logic [DW-1:0]     rf_off_data,
  output logic [RIW-1:0]    rf_src_addr,
  input  logic [15:0]       rf_src_data,
  output logic              rf_we,
  output logic [RIW-1:0]    rf_waddr,
  output logic [DW-1:0]     rf_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DW-1:0]     mem_addr,
  output logic [DW/8-1:0]   mem_be,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic              done,
  output logic              align_err,
  output logic              unhandled
);
  localparam int NLANE = DW / 8;
  localparam int LSB   = $clog2(NLANE);
  localparam logic [NLANE-1:0] BE_BYTE = NLANE'(1);
  localparam logic [NLANE-1:0] BE_HALF = NLANE'(3);

  logic rst_s;
  rol_rst_sync u_rst (.clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_s));

  dec_t dec;
  rol_decode u_dec (.instr_i(instr), .dec_o(dec));

  st_e            st;
  op_e            op_q;
  logic [RIW-1:0] ro_q, rb_q, rd_q;
  logic [DW-1:0]  ea_q, ea_d;
  logic [15:0]    sd_q;
  logic           unh_q, unh_d;
  logic           take, addr_en, misalign, is_store;

  // next-state values
  always_comb begin
    take     = instr_valid && (st == ST_IDLE) && dec.match;
    unh_d    = instr_valid && (st == ST_IDLE) && !dec.match;
    addr_en  = (st == ST_ADDR);
    ea_d     = rf_base_data + rf_off_data;
    misalign = (op_q != OP_LDSB) && ea_d[0];
    is_store = (op_q == OP_STH);
  end

  rol_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s),
    .valid_i    (instr_valid),
    .match_i    (dec.match),
    .misalign_i (misalign),
    .store_i    (is_store),
    .st_o       (st)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      op_q  <= OP_STH;
      ro_q  <= '0;
      rb_q  <= '0;
      rd_q  <= '0;
      ea_q  <= '0;
      sd_q  <= '0;
      unh_q <= 1'b0;
    end else begin
      if (take) begin
        op_q <= dec.op;
        ro_q <= dec.ro;
        rb_q <= dec.rb;
        rd_q <= dec.rd;
      end
      if (addr_en) begin
        ea_q <= ea_d;
        sd_q <= rf_src_data;
      end
      unh_q <= unh_d;
    end
  end

  logic [DW-1:0] ext;
  rol_lane #(.DW(DW)) u_lane (
    .rdata_i (mem_rdata),
    .off_i   (ea_q[LSB-1:0]),
    .op_i    (op_q),
    .ext_o   (ext)
  );

  always_comb begin
    if (op_q == OP_LDSB) mem_be = BE_BYTE << ea_q[LSB-1:0];
    else                 mem_be = BE_HALF << {ea_q[LSB-1:1], 1'b0};
  end

  assign busy         = (st != ST_IDLE);
  assign rf_base_addr = rb_q;
  assign rf_off_addr  = ro_q;
  assign rf_src_addr  = rd_q;
  assign mem_req      = (st == ST_MEM);
  assign mem_we       = (st == ST_MEM) && is_store;
  assign mem_addr     = ea_q;
  assign mem_wdata    = {(DW/16){sd_q}};
  assign rf_we        = (st == ST_WB);
  assign rf_waddr     = rd_q;
  assign rf_wdata     = ext;
  assign done         = ((st == ST_MEM) && is_store) || (st == ST_WB) || (st == ST_FAULT);
  assign align_err    = (st == ST_FAULT);
  assign unhandled    = unh_q;

  AST_STORE_NO_RFWE: assert property (@(posedge clk) disable iff (!rst_s)
    mem_we |-> !rf_we); // R3

  AST_LDH_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_s)
    (rf_we && op_q == OP_LDH) |-> (rf_wdata[DW-1:16] == '0)); // R4

  AST_LDSB_FILL: assert property (@(posedge clk) disable iff (!rst_s)
    (rf_we && op_q == OP_LDSB) |-> (rf_wdata[DW-1:8] == {(DW-8){rf_wdata[7]}})); // R5

  AST_LDSH_FILL: assert property (@(posedge clk) disable iff (!rst_s)
    (rf_we && op_q == OP_LDSH) |-> (rf_wdata[DW-1:16] == {(DW-16){rf_wdata[15]}})); // R6

  AST_WB_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_s)
    rf_we |-> $past(mem_req && !mem_we)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done); // R7

  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_s)
    align_err |-> (!mem_req && !rf_we && done)); // R8

  AST_HALF_EVEN: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_req && op_q != OP_LDSB) |-> !mem_addr[0]); // R8

  AST_UNH_QUIET: assert property (@(posedge clk) disable iff (!rst_s)
    unhandled |-> (!mem_req && !rf_we && !done)); // R9
endmodule

// File: tb/regoff_ldst_tb.sv
module regoff_ldst_tb;
  import rol_pkg::*;

  typedef struct {
    int          kind;   // 0 load, 1 store, 2 align fault, 3 unhandled
    int          due;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [2:0]  rd;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [15:0] instr;
  logic        busy;
  logic [2:0]  rf_base_addr, rf_off_addr, rf_src_addr, rf_waddr;
  logic [31:0] rf_base_data, rf_off_data, rf_wdata;
  logic [15:0] rf_src_data;
  logic        rf_we, mem_req, mem_we, done, align_err, unhandled;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  logic [31:0] regs [8];
  logic [31:0] mem  [64];
  logic        set_r, set_m;
  logic [2:0]  set_ri;
  logic [5:0]  set_mi;
  logic [31:0] set_v;
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  exp_t        q[$];

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (rf_we) regs[rf_waddr] <= rf_wdata;
    else if (set_r) regs[set_ri] <= set_v;
    if (mem_req && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end else if (set_m) mem[set_mi] <= set_v;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[7:2]];
  end

  assign rf_base_data = regs[rf_base_addr];
  assign rf_off_data  = regs[rf_off_addr];
  assign rf_src_data  = regs[rf_src_addr][15:0];

  regoff_ldst u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr), .busy(busy),
    .rf_base_addr(rf_base_addr), .rf_base_data(rf_base_data),
    .rf_off_addr(rf_off_addr), .rf_off_data(rf_off_data),
    .rf_src_addr(rf_src_addr), .rf_src_data(rf_src_data),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .align_err(align_err), .unhandled(unhandled)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(logic s, logic h, logic [2:0] ro, logic [2:0] rb, logic [2:0] rd);
    return {4'b0101, h, s, 1'b1, ro, rb, rd};
  endfunction

  task automatic set_reg(input logic [2:0] i, input logic [31:0] v);
    @(negedge clk); set_r = 1'b1; set_ri = i; set_v = v;
    @(negedge clk); set_r = 1'b0;
  endtask

  task automatic set_mem(input logic [5:0] i, input logic [31:0] v);
    @(negedge clk); set_m = 1'b1; set_mi = i; set_v = v;
    @(negedge clk); set_m = 1'b0;
  endtask

  // driver: builds the expectation from the requirements, then offers the word
  task automatic run(input logic [15:0] ins, input bit intrude);
    exp_t e;
    logic [31:0] ea, w;
    logic [7:0]  bv;
    logic [15:0] hv;
    logic s, h;
    @(negedge clk);
    s = ins[10]; h = ins[11];
    ea = regs[ins[5:3]] + regs[ins[8:6]];
    e.addr = ea; e.rd = ins[2:0]; e.data = '0; e.be = '0;
    if (!(ins[15:12] == 4'b0101 && ins[9])) begin
      e.kind = 3; e.due = cyc + 1; e.tag = "R9";
    end else if (!(s && !h) && ea[0]) begin
      e.kind = 2; e.due = cyc + 2; e.tag = "R8";
    end else if (!s && !h) begin
      e.kind = 1; e.due = cyc + 2; e.tag = "R3";
      e.be = ea[1] ? 4'b1100 : 4'b0011;
      e.data = {2{regs[ins[2:0]][15:0]}};
    end else begin
      e.kind = 0; e.due = cyc + 3;
      w  = mem[ea[7:2]];
      bv = w[8*ea[1:0] +: 8];
      hv = w[16*ea[1] +: 16];
      if (s && !h) begin
        e.tag = "R5"; e.be = 4'b0001 << ea[1:0]; e.data = {{24{bv[7]}}, bv};
      end else begin
        e.be = ea[1] ? 4'b1100 : 4'b0011;
        if (s) begin e.tag = "R6"; e.data = {{16{hv[15]}}, hv}; end
        else   begin e.tag = "R4"; e.data = {16'h0, hv}; end
      end
    end
    q.push_back(e);
    instr_valid = 1'b1; instr = ins;
    @(negedge clk);
    if (intrude) begin
      instr = enc(1'b0, 1'b0, 3'd1, 3'd0, 3'd3);
      @(negedge clk);
      instr = 16'h7A11;
      @(negedge clk);
    end
    instr_valid = 1'b0; instr = 16'h0;
    repeat (4) @(negedge clk);
  endtask

  task automatic monitor_step();
    exp_t e;
    if ((rf_we || mem_we) && !done)
      chk(1'b0, "R10", "write outside a completion", {30'h0, rf_we, mem_we}, 32'h0);
    if (mem_req && !mem_we) begin
      if (q.size() == 0) chk(1'b0, "R10", "read with nothing pending", mem_addr, 32'h0);
      else begin
        chk(mem_addr === q[0].addr, "R2", "read address", mem_addr, q[0].addr);
        chk(mem_be === q[0].be, q[0].tag, "read enables", {28'h0, mem_be}, {28'h0, q[0].be});
      end
    end
    if (done || unhandled) begin
      if (q.size() == 0) chk(1'b0, "R10", "unexpected completion", {30'h0, done, unhandled}, 32'h0);
      else begin
        e = q.pop_front();
        chk(cyc == e.due, "R7", "completion cycle", cyc, e.due);
        chk(align_err === (e.kind == 2), "R8", "align flag", {31'h0, align_err}, {31'h0, e.kind == 2});
        case (e.kind)
          0: begin
            chk(rf_we === 1'b1, e.tag, "write strobe", {31'h0, rf_we}, 32'h1);
            chk(rf_waddr === e.rd, "R1", "write index", {29'h0, rf_waddr}, {29'h0, e.rd});
            chk(rf_wdata === e.data, e.tag, "load value", rf_wdata, e.data);
          end
          1: begin
            chk(mem_req && mem_we, "R3", "write request", {30'h0, mem_req, mem_we}, 32'h3);
            chk(mem_addr === e.addr, "R2", "write address", mem_addr, e.addr);
            chk(mem_be === e.be, "R3", "write enables", {28'h0, mem_be}, {28'h0, e.be});
            chk(mem_wdata === e.data, "R3", "write data", mem_wdata, e.data);
          end
          2: chk(!mem_req && !rf_we && done, "R8", "fault quiet", {29'h0, mem_req, rf_we, done}, 32'h1);
          default: chk(!done && !mem_req && !rf_we, "R9", "unhandled quiet", {29'h0, done, mem_req, rf_we}, 32'h0);
        endcase
      end
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic reset_outputs_check(input string what);
    chk({busy, done, mem_req, mem_we, rf_we, align_err, unhandled} === 7'b0, "R11", what,
        {25'h0, busy, done, mem_req, mem_we, rf_we, align_err, unhandled}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; instr_valid = 1'b0; instr = '0;
    set_r = 1'b0; set_m = 1'b0; set_ri = '0; set_mi = '0; set_v = '0;
    fork
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R7", "watchdog expired", 32'h0, 32'h1);
        summary();
      end
    join_none
    repeat (3) @(negedge clk);
    reset_outputs_check("outputs during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    reset_outputs_check("outputs after reset");
    fork
      forever begin @(negedge clk); monitor_step(); end
    join_none

    set_reg(3'd0, 32'h0000_0010);
    set_reg(3'd1, 32'h0000_0000);
    set_reg(3'd3, 32'hABCD_9876);
    set_reg(3'd4, 32'hFFFF_FFF0);
    set_reg(3'd5, 32'h0000_0014);
    set_mem(6'd4, 32'h8A7F_C301);
    set_mem(6'd5, 32'h1234_F00D);
    set_mem(6'd1, 32'h5566_7788);

    // R4: zero-extended halfword, both lanes
    run(enc(1'b0, 1'b1, 3'd1, 3'd0, 3'd2), 1'b0);
    set_reg(3'd1, 32'd2);
    run(enc(1'b0, 1'b1, 3'd1, 3'd0, 3'd7), 1'b0);
    // R5: sign-extended byte on every lane
    for (int k = 0; k < 4; k++) begin
      set_reg(3'd1, k);
      run(enc(1'b1, 1'b0, 3'd1, 3'd0, 3'd2), 1'b0);
    end
    // R6: sign-extended halfword, negative and positive
    set_reg(3'd1, 32'd0);
    run(enc(1'b1, 1'b1, 3'd1, 3'd0, 3'd6), 1'b0);
    set_reg(3'd1, 32'd6);
    run(enc(1'b1, 1'b1, 3'd1, 3'd0, 3'd6), 1'b0);
    // R2: address sum wraps past the top
    run(enc(1'b1, 1'b1, 3'd5, 3'd4, 3'd2), 1'b0);
    run(enc(1'b1, 1'b0, 3'd5, 3'd4, 3'd2), 1'b0);
    // R3: store both halfword lanes, then read back
    set_reg(3'd1, 32'd0);
    run(enc(1'b0, 1'b0, 3'd1, 3'd0, 3'd3), 1'b0);
    set_reg(3'd3, 32'h1111_5AA5);
    set_reg(3'd1, 32'd2);
    run(enc(1'b0, 1'b0, 3'd1, 3'd0, 3'd3), 1'b0);
    run(enc(1'b1, 1'b1, 3'd1, 3'd0, 3'd2), 1'b0);
    set_reg(3'd1, 32'd0);
    run(enc(1'b0, 1'b1, 3'd1, 3'd0, 3'd2), 1'b0);
    // R8: odd halfword accesses refused, odd byte load accepted
    set_reg(3'd1, 32'd1);
    run(enc(1'b0, 1'b1, 3'd1, 3'd0, 3'd2), 1'b0);
    run(enc(1'b0, 1'b0, 3'd1, 3'd0, 3'd3), 1'b0);
    set_reg(3'd1, 32'd3);
    run(enc(1'b1, 1'b1, 3'd1, 3'd0, 3'd2), 1'b0);
    run(enc(1'b1, 1'b0, 3'd1, 3'd0, 3'd2), 1'b0);
    // R8: memory untouched by the refused store
    set_reg(3'd1, 32'd0);
    run(enc(1'b0, 1'b1, 3'd1, 3'd0, 3'd2), 1'b0);
    // R9: non-matching words
    run(16'h5811, 1'b0);
    run(16'h7A11, 1'b0);
    run(16'h4E3F, 1'b0);
    // R1: destination equal to base register
    set_reg(3'd7, 32'd1);
    run(enc(1'b1, 1'b0, 3'd7, 3'd0, 3'd0), 1'b0);
    // R10: offers while busy are ignored
    set_reg(3'd0, 32'h0000_0010);
    set_reg(3'd1, 32'd2);
    run(enc(1'b1, 1'b1, 3'd1, 3'd0, 3'd5), 1'b1);

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R10", "pending expectations left", q.size(), 32'h0);
    summary();
  end
endmodule